// File: doc/BRIEF.md
# Compressed Program-Counter Trace Buffer

This block records a stream of 18-bit program-counter values into a circular trace RAM of 64 lines of 20 bits each. A capture session starts with an arm pulse, which also selects one of two line formats. In the plain format every valid PC becomes one line that carries the address, a destination flag and a vector flag. In the compressed format the block keeps the upper twelve PC bits as a running base. A PC that shares the base is stored as a 6-bit offset, and up to three offsets share one line. A PC that does not share the base starts a new base line.

Capture runs until a trigger pulse arrives, so the buffer keeps the most recent history. Older lines are overwritten once the write position wraps, and a sticky flag records the wrap. A trigger flushes any half-filled line before capture stops. The contents are read through an index port in which index 0 is always the oldest surviving line. After a wrap, the oldest compressed lines may have lost their base. Whoever decodes the trace starts from the first base line found after the write position.

The controller is one state machine with six states. IDLE means not capturing. PLAIN captures in the uncompressed format. NEED_BASE means compressed capture with no base yet. HAVE_BASE means a base is known and no offset line is open. PACKING means an offset line is open with one or two entries. PEND means a new base is waiting to be written. The transitions are:
- arm goes from any state to NEED_BASE or PLAIN.
- trigger goes from any capturing state to IDLE.
- NEED_BASE goes to HAVE_BASE on a valid PC.
- HAVE_BASE goes to PACKING on a matching PC.
- PACKING goes to HAVE_BASE when its third offset fills.
- PACKING goes to PEND on a non-matching PC.
- PEND goes to PACKING on a matching PC, stays in PEND on another non-matching PC, and goes to HAVE_BASE when no PC is valid.

Top module: `pc_trace_buf`

## Requirements
- R1: An arm pulse sets the write pointer to 0, clears the rollover flag and starts capture. The format is sampled in that cycle: `cmp_mode_i`=0 selects plain and 1 selects compressed. A PC that is valid in the arm cycle is not recorded.
- R2: In plain capture, each valid PC writes one line at the write pointer, and the pointer advances by one in the same clock edge. The line layout is: bit 19 is the destination flag, bit 18 is the vector flag, and bits 17:0 are the PC.
- R3: In plain capture, a set vector flag forces line bit 19 to 1, whatever the destination input is.
- R4: The first line written after a compressed arm is a base line. Its tag in bits 19:18 is 00 and bits 17:0 hold the full PC.
- R5: A PC whose bits 17:6 equal the current base is packed as its bits 5:0. The first entry goes to bits 5:0, the second to bits 11:6 and the third to bits 17:12. A line becomes complete with its third entry and is then written with tag 11.
- R6: A PC that does not match the base closes any open line, and the block then writes a base line for that PC. An open line is written with tag 01 (one entry) or 10 (two entries), and its unused fields are 0. When a line was open, the new base line is written in the following cycle.
- R7: In compressed capture, the destination and vector inputs are not recorded and have no effect on any line.
- R8: A trigger stops capture. A partly filled line or a waiting base line is written in the trigger cycle. Valid PCs after that do not move the pointer until the next arm.
- R9: After line 63 is written, the pointer returns to 0 and older lines are overwritten. The rollover flag is set on the first wrap and stays set until the next arm.
- R10: `rd_data_o` shows the line at logical index `rd_idx_i` one clock after the index is presented. Index 0 is the oldest line: physical line 0 before a wrap, and the line at the write pointer after a wrap.
- R11: After reset the pointer and the rollover flag are 0, and valid PCs are ignored until the first arm.
- R12: When arm is high in the same cycle as a trigger or a valid PC, the arm takes effect and the other inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Start a capture session (pulse) |
| trig_i | input | 1 | Stop capture and flush (pulse) |
| cmp_mode_i | input | 1 | Format for the next arm: 0 plain, 1 compressed |
| pc_vld_i | input | 1 | PC strobe |
| pc_i | input | 18 | Program counter |
| pc_dst_i | input | 1 | 1 when the address is a destination |
| pc_vec_i | input | 1 | 1 when the address is a vector destination |
| rd_idx_i | input | 6 | Logical read index, 0 = oldest |
| rd_data_o | output | 20 | Line at the index given in the previous cycle |
| wr_ptr_o | output | 6 | Next line to be written |
| rollover_o | output | 1 | Sticky wrap indication |

## Verification
Every line write, the pointer step and the rollover flag are visible one edge after the PC, arm or trigger that causes them. The one exception is the base line that follows a closed offset line, which lands one edge later. The bench drives inputs on the falling edge, advances its queue-based model by one clock, and compares the pointer and the flag at the next falling edge. That way the model's one-write-per-cycle queue has to agree with the delayed base write. Read data is due one edge after the index is applied, so every readout check waits exactly one rising edge before it samples.

// File: rtl/pctb_pkg.sv
package pctb_pkg;

    localparam int PC_W   = 18;
    localparam int OFS_W  = 6;
    localparam int TAG_W  = 2;
    localparam int BASE_W = PC_W - OFS_W;
    localparam int LINE_W = TAG_W + PC_W;
    localparam int OPEN_W = 2 * OFS_W;

    localparam logic [TAG_W-1:0] TAG_BASE  = 2'b00;
    localparam logic [TAG_W-1:0] TAG_ONE   = 2'b01;
    localparam logic [TAG_W-1:0] TAG_TWO   = 2'b10;
    localparam logic [TAG_W-1:0] TAG_THREE = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PLAIN     = 3'd1,
        ST_NEED_BASE = 3'd2,
        ST_HAVE_BASE = 3'd3,
        ST_PACKING   = 3'd4,
        ST_PEND      = 3'd5
    } trc_state_e;

endpackage

// File: rtl/pctb_ctrl.sv
module pctb_ctrl
    import pctb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              trig,
    input  logic              cmp_mode,
    input  logic              pc_vld,
    input  logic [PC_W-1:0]   pc,
    input  logic              pc_dst,
    input  logic              pc_vec,
    output logic              wr_en,
    output logic [LINE_W-1:0] wr_data
);

    trc_state_e        state_q, state_n;
    logic [BASE_W-1:0] base_q, base_n;
    logic [OPEN_W-1:0] fld_q, fld_n;
    logic              two_q, two_n;
    logic [PC_W-1:0]   pend_q, pend_n;

    logic [BASE_W-1:0] pc_hi;
    logic [OFS_W-1:0]  pc_lo;
    logic              hit;

    assign pc_hi = pc[PC_W-1:OFS_W];
    assign pc_lo = pc[OFS_W-1:0];
    assign hit   = (pc_hi == base_q);

    function automatic logic [LINE_W-1:0] close_line(input logic two,
                                                     input logic [OPEN_W-1:0] f);
        if (two)
            close_line = {TAG_TWO, {OFS_W{1'b0}}, f};
        else
            close_line = {TAG_ONE, {OPEN_W{1'b0}}, f[OFS_W-1:0]};
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            fld_q   <= '0;
            two_q   <= 1'b0;
            pend_q  <= '0;
        end else begin
            state_q <= state_n;
            base_q  <= base_n;
            fld_q   <= fld_n;
            two_q   <= two_n;
            pend_q  <= pend_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        base_n  = base_q;
        fld_n   = fld_q;
        two_n   = two_q;
        pend_n  = pend_q;
        if (arm) begin
            state_n = cmp_mode ? ST_NEED_BASE : ST_PLAIN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_n = ST_IDLE;
                ST_PLAIN: begin
                    if (trig) state_n = ST_IDLE;
                end
                ST_NEED_BASE: begin
                    if (trig) begin
                        state_n = ST_IDLE;
                    end else if (pc_vld) begin
                        base_n  = pc_hi;
                        state_n = ST_HAVE_BASE;
                    end
                end
                ST_HAVE_BASE, ST_PEND: begin
                    if (trig) begin
                        state_n = ST_IDLE;
                    end else if (pc_vld) begin
                        if (hit) begin
                            fld_n[OFS_W-1:0] = pc_lo;
                            two_n   = 1'b0;
                            state_n = ST_PACKING;
                        end else begin
                            base_n  = pc_hi;
                            pend_n  = pc;
                            state_n = state_q;
                        end
                    end else if (state_q == ST_PEND) begin
                        state_n = ST_HAVE_BASE;
                    end
                end
                ST_PACKING: begin
                    if (trig) begin
                        state_n = ST_IDLE;
                    end else if (pc_vld) begin
                        if (hit) begin
                            if (two_q) begin
                                state_n = ST_HAVE_BASE;
                            end else begin
                                fld_n[OPEN_W-1:OFS_W] = pc_lo;
                                two_n = 1'b1;
                            end
                        end else begin
                            base_n  = pc_hi;
                            pend_n  = pc;
                            state_n = ST_PEND;
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en   = 1'b0;
        wr_data = '0;
        if (!arm) begin
            unique case (state_q)
                ST_IDLE: wr_en = 1'b0;
                ST_PLAIN: begin
                    if (!trig && pc_vld) begin
                        wr_en   = 1'b1;
                        wr_data = {pc_dst | pc_vec, pc_vec, pc};
                    end
                end
                ST_NEED_BASE: begin
                    if (!trig && pc_vld) begin
                        wr_en   = 1'b1;
                        wr_data = {TAG_BASE, pc};
                    end
                end
                ST_HAVE_BASE: begin
                    if (!trig && pc_vld && !hit) begin
                        wr_en   = 1'b1;
                        wr_data = {TAG_BASE, pc};
                    end
                end
                ST_PACKING: begin
                    if (trig) begin
                        wr_en   = 1'b1;
                        wr_data = close_line(two_q, fld_q);
                    end else if (pc_vld) begin
                        if (hit && two_q) begin
                            wr_en   = 1'b1;
                            wr_data = {TAG_THREE, pc_lo, fld_q};
                        end else if (!hit) begin
                            wr_en   = 1'b1;
                            wr_data = close_line(two_q, fld_q);
                        end
                    end
                end
                ST_PEND: begin
                    wr_en   = 1'b1;
                    wr_data = {TAG_BASE, pend_q};
                end
            endcase
        end
    end

    // R8 and R11: no line is written while capture is stopped
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !wr_en);

    p_vec_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PLAIN && wr_en) |-> (!wr_data[LINE_W-2] || wr_data[LINE_W-1]));

    p_first_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NEED_BASE && wr_en) |-> (wr_data[LINE_W-1 -: TAG_W] == TAG_BASE));

    p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state_q != ST_PLAIN && wr_data[LINE_W-1 -: TAG_W] == TAG_ONE)
        |-> (wr_data[PC_W-1:OFS_W] == '0));

    p_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PACKING && pc_vld && !trig && !arm && !hit) |=> (state_q == ST_PEND));

    p_arm_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (state_q == ST_NEED_BASE || state_q == ST_PLAIN));

endmodule

// File: rtl/pctb_ptr.sv
module pctb_ptr #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    output logic [AW-1:0] ptr,
    output logic          roll
);

    logic [AW-1:0] ptr_q;
    logic          roll_q;
    logic          at_top;

    assign at_top = (ptr_q == AW'(DEPTH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            roll_q <= 1'b0;
        end else if (clr) begin
            ptr_q  <= '0;
            roll_q <= 1'b0;
        end else if (wr_en) begin
            ptr_q <= ptr_q + 1'b1;
            if (at_top) roll_q <= 1'b1;
        end
    end

    assign ptr  = ptr_q;
    assign roll = roll_q;

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (ptr_q == AW'($past(ptr_q) + 1'b1)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr) |=> $stable(ptr_q));

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && at_top) |=> roll_q);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_q && !clr) |=> roll_q);

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr_q == '0 && !roll_q));

endmodule

// File: rtl/pctb_ram.sv
module pctb_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 20,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/pc_trace_buf.sv
module pc_trace_buf
    import pctb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              trig_i,
    input  logic              cmp_mode_i,
    input  logic              pc_vld_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic              pc_dst_i,
    input  logic              pc_vec_i,
    input  logic [AW-1:0]     rd_idx_i,
    output logic [LINE_W-1:0] rd_data_o,
    output logic [AW-1:0]     wr_ptr_o,
    output logic              rollover_o
);

    logic              wr_en;
    logic [LINE_W-1:0] wr_data;
    logic [AW-1:0]     ptr;
    logic              roll;
    logic [AW-1:0]     rd_phys;

    pctb_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm_i),
        .trig     (trig_i),
        .cmp_mode (cmp_mode_i),
        .pc_vld   (pc_vld_i),
        .pc       (pc_i),
        .pc_dst   (pc_dst_i),
        .pc_vec   (pc_vec_i),
        .wr_en    (wr_en),
        .wr_data  (wr_data)
    );

    pctb_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (arm_i),
        .wr_en (wr_en),
        .ptr   (ptr),
        .roll  (roll)
    );

    // oldest line sits at the write pointer once the buffer has wrapped
    assign rd_phys = roll ? AW'(ptr + rd_idx_i) : rd_idx_i;

    pctb_ram #(.DEPTH(DEPTH), .WIDTH(LINE_W)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (ptr),
        .wdata (wr_data),
        .raddr (rd_phys),
        .rdata (rd_data_o)
    );

    assign wr_ptr_o   = ptr;
    assign rollover_o = roll;

    p_arm_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |-> !wr_en);

endmodule

// File: tb/pc_trace_buf_bench.sv
module pc_trace_buf_bench;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 0, trig_i = 0, cmp_mode_i = 0, pc_vld_i = 0;
    logic [17:0] pc_i = '0;
    logic        pc_dst_i = 0, pc_vec_i = 0;
    logic [5:0]  rd_idx_i = '0;
    logic [19:0] rd_data_o;
    logic [5:0]  wr_ptr_o;
    logic        rollover_o;

    always #4 clk = ~clk;

    pc_trace_buf u_pc_trace_buf (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .trig_i(trig_i),
        .cmp_mode_i(cmp_mode_i), .pc_vld_i(pc_vld_i), .pc_i(pc_i),
        .pc_dst_i(pc_dst_i), .pc_vec_i(pc_vec_i), .rd_idx_i(rd_idx_i),
        .rd_data_o(rd_data_o), .wr_ptr_o(wr_ptr_o), .rollover_o(rollover_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference
    logic [19:0] mmem [DEPTH];
    logic [19:0] mq [$];
    int          mptr = 0;
    bit          mroll = 0;
    bit          mact = 0;
    bit          mcmp = 0;
    bit          mhave = 0;
    int          mbase = 0;
    int          mcnt = 0;
    int          mf [3];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] open_line();
        if (mcnt == 2) return {2'b10, 6'd0, 6'(mf[1]), 6'(mf[0])};
        return {2'b01, 12'd0, 6'(mf[0])};
    endfunction

    task automatic model_step(input bit a, input bit t, input bit v, input logic [17:0] pc,
                              input bit sd, input bit vc, input bit md);
        if (a) begin
            mptr = 0; mroll = 0; mq.delete(); mact = 1; mcmp = md; mhave = 0; mcnt = 0;
            return;
        end
        if (mact) begin
            if (t) begin
                if (mcmp && mcnt > 0) mq.push_back(open_line());
                mact = 0; mcnt = 0;
            end else if (v) begin
                if (!mcmp) begin
                    mq.push_back({sd | vc, vc, pc});
                end else if (!mhave) begin
                    mq.push_back({2'b00, pc}); mbase = int'(pc >> 6); mhave = 1;
                end else if (int'(pc >> 6) == mbase) begin
                    mf[mcnt] = int'(pc[5:0]); mcnt++;
                    if (mcnt == 3) begin
                        mq.push_back({2'b11, 6'(mf[2]), 6'(mf[1]), 6'(mf[0])});
                        mcnt = 0;
                    end
                end else begin
                    if (mcnt > 0) mq.push_back(open_line());
                    mq.push_back({2'b00, pc}); mbase = int'(pc >> 6); mcnt = 0;
                end
            end
        end
        if (mq.size() > 0) begin
            mmem[mptr] = mq.pop_front();
            mptr = (mptr + 1) % DEPTH;
            if (mptr == 0) mroll = 1;
        end
    endtask

    // one clock: compare state, drive inputs, advance model
    task automatic cyc(input bit a, input bit t, input bit v, input logic [17:0] pc,
                       input bit sd, input bit vc, input bit md);
        chk(wr_ptr_o == 6'(mptr), "R2 R9 pointer", 32'(wr_ptr_o), 32'(mptr));
        chk(rollover_o == mroll, "R9 R1 rollover", 32'(rollover_o), 32'(mroll));
        arm_i = a; trig_i = t; pc_vld_i = v; pc_i = pc; pc_dst_i = sd; pc_vec_i = vc; cmp_mode_i = md;
        model_step(a, t, v, pc, sd, vc, md);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0, 0, 0);
    endtask

    task automatic pcv(input logic [17:0] pc, input bit sd, input bit vc);
        cyc(0, 0, 1, pc, sd, vc, 0);
    endtask

    task automatic rd_line(input int idx, output logic [19:0] d);
        rd_idx_i = 6'(idx);
        @(posedge clk);
        @(negedge clk);
        d = rd_data_o;
    endtask

    task automatic readout_all();
        int n;
        logic [19:0] d;
        n = mroll ? DEPTH : mptr;
        for (int i = 0; i < n; i++) begin
            rd_line(i, d);
            chk(d == mmem[mroll ? (mptr + i) % DEPTH : i], "R10 readout vs model", 32'(d),
                32'(mmem[mroll ? (mptr + i) % DEPTH : i]));
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [19:0] d;
        logic [31:0] lf;
        logic [17:0] cur;
        bit found;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state and PCs before any arm
        chk(wr_ptr_o == 0, "R11 reset pointer", 32'(wr_ptr_o), 0);
        chk(rollover_o == 0, "R11 reset rollover", 32'(rollover_o), 0);
        pcv(18'h00123, 1, 0);
        pcv(18'h00456, 0, 1);
        idle(1);
        chk(wr_ptr_o == 0, "R11 ignored before arm", 32'(wr_ptr_o), 0);

        // R2 R3: plain format
        cyc(1, 0, 1, 18'h11111, 0, 0, 0);
        pcv(18'h2ABCD, 0, 0);
        pcv(18'h10001, 1, 0);
        pcv(18'h3FFFF, 0, 1);
        cyc(0, 1, 0, '0, 0, 0, 0);
        idle(1);
        chk(wr_ptr_o == 3, "R1 arm-cycle PC dropped, R2 count", 32'(wr_ptr_o), 3);
        rd_line(0, d); chk(d == 20'h2ABCD, "R2 plain source line", 32'(d), 32'h2ABCD);
        rd_line(1, d); chk(d == 20'h90001, "R2 plain destination line", 32'(d), 32'h90001);
        rd_line(2, d); chk(d == 20'hFFFFF, "R3 vector forces destination", 32'(d), 32'hFFFFF);

        // R4 R5 R6 R7 R8: compressed directed sequence
        cyc(1, 0, 0, '0, 0, 0, 1);
        pcv(18'h12345, 1, 1);
        pcv(18'h12341, 1, 0);
        pcv(18'h12342, 0, 1);
        pcv(18'h12343, 1, 1);
        pcv(18'h12300, 0, 0);
        pcv(18'h12305, 1, 0);
        pcv(18'h30000, 0, 0);
        pcv(18'h30001, 0, 1);
        pcv(18'h30002, 0, 0);
        cyc(0, 1, 0, '0, 0, 0, 0);
        pcv(18'h11111, 0, 0);
        pcv(18'h30003, 0, 0);
        idle(1);
        chk(wr_ptr_o == 6, "R8 pointer frozen after trigger", 32'(wr_ptr_o), 6);
        rd_line(0, d); chk(d == 20'h12345, "R4 first line is base", 32'(d), 32'h12345);
        rd_line(1, d); chk(d == {2'b11, 6'd3, 6'd2, 6'd1}, "R5 R7 three offsets", 32'(d), 32'hC3081);
        rd_line(2, d); chk(d == 20'h12300, "R6 base on mismatch", 32'(d), 32'h12300);
        rd_line(3, d); chk(d == 20'h40005, "R6 one-entry closed line", 32'(d), 32'h40005);
        rd_line(4, d); chk(d == 20'h30000, "R6 delayed base line", 32'(d), 32'h30000);
        rd_line(5, d); chk(d == 20'h80081, "R8 flushed two-entry line", 32'(d), 32'h80081);

        // R6: chained base changes while a base is waiting
        cyc(1, 0, 0, '0, 0, 0, 1);
        pcv(18'h00000, 0, 0);
        pcv(18'h00001, 0, 0);
        pcv(18'h01000, 0, 0);
        pcv(18'h02000, 0, 0);
        pcv(18'h03000, 0, 0);
        idle(2);
        chk(wr_ptr_o == 5, "R6 chained bases one per cycle", 32'(wr_ptr_o), 5);
        cyc(0, 1, 0, '0, 0, 0, 0);
        idle(1);
        readout_all();

        // R12: arm wins over trigger and PC in the same cycle
        pcv(18'h01001, 0, 0);
        cyc(1, 1, 1, 18'h05555, 0, 0, 0);
        chk(wr_ptr_o == 0, "R12 arm priority pointer", 32'(wr_ptr_o), 0);
        pcv(18'h00777, 0, 0);
        chk(wr_ptr_o == 1, "R12 capture still running", 32'(wr_ptr_o), 1);

        // R9 R10: plain wrap
        cyc(1, 0, 0, '0, 0, 0, 0);
        for (int i = 0; i < 70; i++) pcv(18'(i * 37 + 5), 0, 0);
        cyc(0, 1, 0, '0, 0, 0, 0);
        idle(1);
        chk(rollover_o == 1, "R9 rollover set", 32'(rollover_o), 1);
        chk(wr_ptr_o == 6, "R9 pointer after wrap", 32'(wr_ptr_o), 6);
        rd_line(0, d); chk(d == 20'(6 * 37 + 5), "R10 oldest after wrap", 32'(d), 32'(6 * 37 + 5));
        readout_all();
        cyc(1, 0, 0, '0, 0, 0, 1);
        chk(rollover_o == 0, "R1 re-arm clears rollover", 32'(rollover_o), 0);

        // R5 R6 R9 R10: long compressed run with wrap
        lf = 32'h1ACE5EED;
        cur = 18'h0F000;
        for (int i = 0; i < 500; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            if (lf[3:0] < 4'd11) cur = {cur[17:6], lf[13:8]};
            else cur = lf[29:12];
            cyc(0, 0, lf[4] | lf[5], cur, lf[6], lf[7], 0);
        end
        cyc(0, 1, 0, '0, 0, 0, 0);
        idle(1);
        chk(rollover_o == 1, "R9 compressed wrap", 32'(rollover_o), 1);
        readout_all();
        found = 0;
        for (int i = 0; i < DEPTH && !found; i++) begin
            rd_line(i, d);
            if (d[19:18] == 2'b00) found = 1;
        end
        chk(found, "R9 base line present after pointer", 32'(found), 1);

        summary();
        $finish;
    end

endmodule